// File: doc/BRIEF.md
# DRAM Strobe-Order Refresh and Test-Mode Decoder

This block is the device-side control of a multiplexed-address DRAM. It watches the sampled row strobe, column strobe and write strobe. From the order in which they change, it decides what each row cycle is: an ordinary access, a refresh that uses the address pins, a refresh that uses the internal row counter, a hidden refresh that keeps read data on the outputs, a self-refresh, or entry into the compressed test mode. Every row activation produces a one-cycle refresh request that carries the row to be restored. The block owns the 10-bit internal refresh counter and the timer that keeps self-refresh running.

The storage array is a small abstract model that is addressed by the low column bits. It exists so that reads, writes and the compressed test can be seen at the data pins. In test mode, data bit 0 is written into eight cells at once: all data bits of an even/odd column pair. A read then returns all ones on every data pin when those eight cells agree, and all zeros when any of them differs. The strobes are active low and are sampled on the clock. An edge is a change between two consecutive samples.

Top module: `dram_refresh_decode`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are as follows: rf_valid 0, cyc_kind 0 (idle), test_mode 0, self_ref 0, dq_oe 0, dq_out 0. The internal counter holds 0, and only reset clears it.
- R2: On the sample where ras_n is first low and cas_n is high, the next clock gives a one-cycle rf_valid with rf_row equal to addr at that sample, and cyc_kind 1 (access).
- R3: On the sample where ras_n is first low and cas_n is already low (a fall in the same sample counts as earlier), the next clock gives rf_valid with rf_row equal to the internal counter. addr is ignored. The counter advances by one, cyc_kind becomes 3 and test_mode clears. With cas_n held low, every further row cycle repeats this.
- R4: The internal counter wraps from 1023 to 0.
- R5: An access cycle that sees no cas_n fall before ras_n returns high becomes cyc_kind 2 (row-address-only refresh) at that rise. It clears test_mode and leaves dq_oe at 0.
- R6: A counter-driven cycle that starts while dq_oe is 1 and we_n is high is a hidden refresh, cyc_kind 4. dq_oe and dq_out stay unchanged.
- R7: A cas_n fall inside an access cycle latches column addr[3:0]. With we_n high the word is read: dq_oe becomes 1 and dq_out shows the word. With we_n low, dq_in is written and dq_oe becomes 0. Read data stays driven while cas_n is high and ras_n is low. The first sample with both strobes high clears dq_oe.
- R8: In a counter-driven cycle, the SR_ENTRY-th consecutive sample with both strobes low after the row fall sets self_ref and sets cyc_kind 5.
- R9: In self-refresh, every SR_INTERVAL clocks give rf_valid with the counter row, and the counter advances.
- R10: A sample with ras_n and cas_n both high ends self-refresh on the next clock.
- R11: A counter-driven cycle that starts with we_n low sets test_mode and cyc_kind 6, and it still refreshes the counter row.
- R12: In test mode, a write stores dq_in[0] in all bits of columns {c[3:1],0} and {c[3:1],1}. A read of either column gives 4'hF if those eight bits are equal and 4'h0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Power-on reset, active low |
| ras_n | input | 1 | Sampled row strobe, active low |
| cas_n | input | 1 | Sampled column strobe, active low |
| we_n | input | 1 | Sampled write strobe, active low |
| addr | input | 10 | Multiplexed row/column address |
| dq_in | input | 4 | Write data |
| rf_valid | output | 1 | One-cycle refresh request |
| rf_row | output | 10 | Row to refresh |
| cyc_kind | output | 3 | Class of the latest cycle |
| test_mode | output | 1 | Compressed test mode active |
| self_ref | output | 1 | Self-refresh active |
| dq_out | output | 4 | Read data or compressed result |
| dq_oe | output | 1 | Output drive enable |

## Verification
The bench goes after strobe orderings that differ by a single sample. A design that tests cas_n on the wrong side of the row edge would refresh the pin row during a counter cycle, or the counter row during an access. A decoder that forgot the held read data would class a hidden refresh as a plain one, or drop the outputs during it. The bench drives the counter across 1023 to catch a missing wrap. It holds both strobes low across the self-refresh threshold, so an off-by-one entry or interval count shows up as a pulse one clock early or late. Test mode is read with equal and with unequal pairs, which exposes a compare over fewer than eight bits or a write that skips the partner column.

// File: rtl/drd_pkg.sv
package drd_pkg;

  typedef enum logic [2:0] {
    K_IDLE    = 3'd0,
    K_ACCESS  = 3'd1,
    K_RASONLY = 3'd2,
    K_CBR     = 3'd3,
    K_HIDDEN  = 3'd4,
    K_SELF    = 3'd5,
    K_TESTIN  = 3'd6
  } cyc_kind_t;

  // Class of a counter-driven cycle from the write strobe and held output (R6, R11)
  function automatic cyc_kind_t kind_for_int(input logic we_n, input logic oe_held);
    if (!we_n)        return K_TESTIN;
    else if (oe_held) return K_HIDDEN;
    else              return K_CBR;
  endfunction

  // Timer reaches a count limit on this clock
  function automatic logic hits(input int unsigned tmr, input int unsigned limit);
    return (tmr + 1) == limit;
  endfunction

endpackage

// File: rtl/drd_strobe_dec.sv
module drd_strobe_dec
  import drd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  input  logic      self_ref,
  input  logic      dq_oe,
  input  logic      sr_enter,
  output logic      ext_act,
  output logic      int_fall,
  output logic      col_strobe,
  output logic      col_write,
  output logic      int_cyc,
  output logic      test_mode,
  output cyc_kind_t kind
);
  logic ras_q, cas_q, acc_cyc, cas_seen;
  logic ras_fall, ras_rise, cas_fall, live, ras_only_end;

  assign ras_fall     = ras_q & ~ras_n;
  assign ras_rise     = ~ras_q & ras_n;
  assign cas_fall     = cas_q & ~cas_n;
  assign live         = ~self_ref;
  assign ext_act      = live & ras_fall & cas_n;            // R2
  assign int_fall     = live & ras_fall & ~cas_n;           // R3
  assign col_strobe   = live & acc_cyc & ~ras_n & cas_fall; // R7
  assign col_write    = ~we_n;
  assign ras_only_end = live & ras_rise & acc_cyc & ~cas_seen; // R5

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      acc_cyc   <= 1'b0;
      cas_seen  <= 1'b0;
      int_cyc   <= 1'b0;
      test_mode <= 1'b0;
      kind      <= K_IDLE;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_n) begin
        acc_cyc <= 1'b0;
        int_cyc <= 1'b0;
      end
      if (ext_act) begin
        acc_cyc  <= 1'b1;
        cas_seen <= 1'b0;
        kind     <= K_ACCESS;
      end
      if (int_fall) begin
        int_cyc   <= 1'b1;
        kind      <= kind_for_int(we_n, dq_oe);
        test_mode <= ~we_n;                                 // R11
      end
      if (col_strobe) cas_seen <= 1'b1;
      if (ras_only_end) begin
        kind      <= K_RASONLY;
        test_mode <= 1'b0;
      end
      if (sr_enter) kind <= K_SELF;                         // R8
    end
  end
endmodule

// File: rtl/drd_refresh_ctr.sv
module drd_refresh_ctr
  import drd_pkg::*;
#(
  parameter int ROW_W       = 10,
  parameter int SR_ENTRY    = 10000,
  parameter int SR_INTERVAL = 1562
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_fall,
  input  logic             ext_act,
  input  logic             int_cyc,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic [ROW_W-1:0] ext_row,
  output logic             rf_valid,
  output logic [ROW_W-1:0] rf_row,
  output logic             self_ref,
  output logic             sr_enter,
  output logic [ROW_W-1:0] cnt
);
  localparam int TMAX  = (SR_ENTRY > SR_INTERVAL) ? SR_ENTRY : SR_INTERVAL;
  localparam int TMR_W = $clog2(TMAX + 1);

  logic [TMR_W-1:0] tmr;
  logic hold_low, both_high, sr_tick;

  assign hold_low  = int_cyc & ~ras_n & ~cas_n;
  assign both_high = ras_n & cas_n;
  assign sr_enter  = ~self_ref & hold_low & hits(32'(tmr), SR_ENTRY);     // R8
  assign sr_tick   = self_ref & ~both_high & hits(32'(tmr), SR_INTERVAL); // R9

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rf_valid <= 1'b0;
      rf_row   <= '0;
      self_ref <= 1'b0;
      tmr      <= '0;
    end else begin
      rf_valid <= 1'b0;
      if (self_ref) begin
        if (both_high) begin                                // R10
          self_ref <= 1'b0;
          tmr      <= '0;
        end else if (sr_tick) begin
          rf_valid <= 1'b1;
          rf_row   <= cnt;
          cnt      <= cnt + ROW_W'(1);
          tmr      <= '0;
        end else begin
          tmr <= tmr + TMR_W'(1);
        end
      end else begin
        if (int_fall) begin                                 // R3, R4 wrap by width
          rf_valid <= 1'b1;
          rf_row   <= cnt;
          cnt      <= cnt + ROW_W'(1);
        end else if (ext_act) begin                         // R2
          rf_valid <= 1'b1;
          rf_row   <= ext_row;
        end
        if (sr_enter) begin
          self_ref <= 1'b1;
          tmr      <= '0;
        end else if (hold_low) begin
          tmr <= tmr + TMR_W'(1);
        end else begin
          tmr <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/drd_test_array.sv
module drd_test_array #(
  parameter int COL_BITS = 4,
  parameter int DQ_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                col_strobe,
  input  logic                col_write,
  input  logic                test_mode,
  input  logic                both_high,
  input  logic [COL_BITS-1:0] col,
  input  logic [DQ_W-1:0]     dq_in,
  output logic [DQ_W-1:0]     dq_out,
  output logic                dq_oe
);
  localparam int DEPTH = 2 ** COL_BITS;

  logic [DQ_W-1:0]     mem [DEPTH];
  logic [COL_BITS-1:0] even_c, odd_c;
  logic [2*DQ_W-1:0]   pair_bits;
  logic                pair_same;

  assign even_c    = {col[COL_BITS-1:1], 1'b0};
  assign odd_c     = {col[COL_BITS-1:1], 1'b1};
  assign pair_bits = {mem[odd_c], mem[even_c]};
  assign pair_same = (&pair_bits) | ~(|pair_bits);          // R12

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      if (both_high) dq_oe <= 1'b0;                          // R7
      if (col_strobe) begin
        if (col_write) begin
          dq_oe <= 1'b0;
          if (test_mode) begin
            mem[even_c] <= {DQ_W{dq_in[0]}};
            mem[odd_c]  <= {DQ_W{dq_in[0]}};
          end else begin
            mem[col] <= dq_in;
          end
        end else begin
          dq_oe  <= 1'b1;
          dq_out <= test_mode ? {DQ_W{pair_same}} : mem[col];
        end
      end
    end
  end
endmodule

// File: rtl/dram_refresh_decode.sv
module dram_refresh_decode
  import drd_pkg::*;
#(
  parameter int ROW_W       = 10,
  parameter int COL_BITS    = 4,
  parameter int DQ_W        = 4,
  parameter int SR_ENTRY    = 10000,
  parameter int SR_INTERVAL = 1562
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [DQ_W-1:0]  dq_in,
  output logic             rf_valid,
  output logic [ROW_W-1:0] rf_row,
  output logic [2:0]       cyc_kind,
  output logic             test_mode,
  output logic             self_ref,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe
);
  logic ext_act, int_fall, col_strobe, col_write, int_cyc, sr_enter;
  logic [ROW_W-1:0] ref_cnt;
  cyc_kind_t kind;

  assign cyc_kind = kind;

  drd_strobe_dec u_dec (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .self_ref(self_ref), .dq_oe(dq_oe), .sr_enter(sr_enter),
    .ext_act(ext_act), .int_fall(int_fall), .col_strobe(col_strobe),
    .col_write(col_write), .int_cyc(int_cyc), .test_mode(test_mode), .kind(kind)
  );

  drd_refresh_ctr #(.ROW_W(ROW_W), .SR_ENTRY(SR_ENTRY), .SR_INTERVAL(SR_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .int_fall(int_fall), .ext_act(ext_act),
    .int_cyc(int_cyc), .ras_n(ras_n), .cas_n(cas_n), .ext_row(addr),
    .rf_valid(rf_valid), .rf_row(rf_row), .self_ref(self_ref),
    .sr_enter(sr_enter), .cnt(ref_cnt)
  );

  drd_test_array #(.COL_BITS(COL_BITS), .DQ_W(DQ_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .col_strobe(col_strobe), .col_write(col_write),
    .test_mode(test_mode), .both_high(ras_n & cas_n), .col(addr[COL_BITS-1:0]),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/drd_checker.sv
module drd_checker #(
  parameter int ROW_W = 10,
  parameter int DQ_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             ext_act,
  input logic             int_fall,
  input logic             sr_enter,
  input logic [ROW_W-1:0] ref_cnt,
  input logic             rf_valid,
  input logic [2:0]       cyc_kind,
  input logic             test_mode,
  input logic             self_ref,
  input logic [DQ_W-1:0]  dq_out,
  input logic             dq_oe
);
  a_r2_ext_request: assert property (@(posedge clk) disable iff (!rst_n)
    ext_act |=> rf_valid && cyc_kind == 3'd1);
  a_r3_int_request: assert property (@(posedge clk) disable iff (!rst_n)
    int_fall |=> rf_valid && ref_cnt != $past(ref_cnt));
  a_r4_counter_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (int_fall && (&ref_cnt)) |=> ref_cnt == '0);
  a_r6_hidden_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (int_fall && dq_oe && we_n) |=> dq_oe && $stable(dq_out));
  a_r7_both_high_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n) |=> !dq_oe);
  a_r8_self_entry: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |=> self_ref && cyc_kind == 3'd5);
  a_r10_self_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (self_ref && ras_n && cas_n) |=> !self_ref);
  a_r11_test_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (int_fall && !we_n) |=> test_mode);
endmodule

bind dram_refresh_decode drd_checker #(.ROW_W(ROW_W), .DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ext_act(ext_act), .int_fall(int_fall), .sr_enter(sr_enter), .ref_cnt(ref_cnt),
  .rf_valid(rf_valid), .cyc_kind(cyc_kind), .test_mode(test_mode),
  .self_ref(self_ref), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/tb_dram_refresh_decode.sv
module tb_dram_refresh_decode;
  localparam int SRE = 40;
  localparam int SRI = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] dq_in = '0;
  logic rf_valid, test_mode, self_ref, dq_oe;
  logic [9:0] rf_row;
  logic [2:0] cyc_kind;
  logic [3:0] dq_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_refresh_decode #(.SR_ENTRY(SRE), .SR_INTERVAL(SRI)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .rf_valid(rf_valid), .rf_row(rf_row),
    .cyc_kind(cyc_kind), .test_mode(test_mode), .self_ref(self_ref),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_row, m_kind, m_t, m_dq;
  bit m_rf, m_test, m_self, m_oe, m_acc, m_saw, m_int, m_rq, m_cq;
  int mem[16];
  string m_rf_tag, m_kind_tag, m_dq_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_row = 0; m_kind = 0; m_t = 0; m_dq = 0;
      m_rf = 0; m_test = 0; m_self = 0; m_oe = 0; m_acc = 0; m_saw = 0; m_int = 0;
      m_rq = 1; m_cq = 1;
      foreach (mem[i]) mem[i] = 0;
      m_rf_tag = "R1"; m_kind_tag = "R1"; m_dq_tag = "R1";
    end else begin
      bit rfall, rrise, cfall;
      rfall = m_rq && !ras_n;
      rrise = !m_rq && ras_n;
      cfall = m_cq && !cas_n;
      m_rf = 0;
      if (m_self) begin
        if (ras_n && cas_n) begin m_self = 0; m_t = 0; end
        else begin
          m_t++;
          if (m_t == SRI) begin
            m_rf = 1; m_row = m_cnt; m_cnt = (m_cnt + 1) % 1024; m_t = 0; m_rf_tag = "R9";
          end
        end
      end else begin
        if (rfall && cas_n) begin
          m_rf = 1; m_row = addr; m_rf_tag = "R2";
          m_kind = 1; m_kind_tag = "R2"; m_acc = 1; m_saw = 0;
        end else if (rfall) begin
          m_rf = 1; m_row = m_cnt; m_cnt = (m_cnt + 1) % 1024; m_rf_tag = "R3";
          m_t = 0; m_int = 1; m_test = !we_n;
          if (!we_n) begin m_kind = 6; m_kind_tag = "R11"; end
          else if (m_oe) begin m_kind = 4; m_kind_tag = "R6"; end
          else begin m_kind = 3; m_kind_tag = "R3"; end
        end else if (m_int && !ras_n && !cas_n) begin
          m_t++;
          if (m_t == SRE) begin m_self = 1; m_kind = 5; m_kind_tag = "R8"; m_t = 0; end
        end else m_t = 0;
        if (m_acc && !ras_n && cfall) begin
          int c, e, o;
          c = addr[3:0]; e = c & 14; o = c | 1;
          m_saw = 1;
          if (!we_n) begin
            m_oe = 0; m_dq_tag = "R7";
            if (m_test) begin mem[e] = dq_in[0] ? 15 : 0; mem[o] = mem[e]; end
            else mem[c] = dq_in;
          end else begin
            m_oe = 1;
            if (m_test) begin
              m_dq = (mem[e] == mem[o] && (mem[e] == 0 || mem[e] == 15)) ? 15 : 0;
              m_dq_tag = "R12";
            end else begin m_dq = mem[c]; m_dq_tag = "R7"; end
          end
        end
        if (rrise && m_acc && !m_saw) begin m_kind = 2; m_kind_tag = "R5"; m_test = 0; end
      end
      if (ras_n) begin m_acc = 0; m_int = 0; end
      if (ras_n && cas_n) m_oe = 0;
      m_rq = ras_n; m_cq = cas_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rf_valid == m_rf, m_rf_tag, rf_valid, m_rf);
      if (m_rf) chk(rf_row == m_row[9:0], m_rf_tag, rf_row, m_row);
      chk(cyc_kind == m_kind[2:0], m_kind_tag, cyc_kind, m_kind);
      chk(test_mode == m_test, "R11", test_mode, m_test);
      chk(self_ref == m_self, "R8", self_ref, m_self);
      chk(dq_oe == m_oe, m_dq_tag, dq_oe, m_oe);
      if (m_oe) chk(dq_out == m_dq[3:0], m_dq_tag, dq_out, m_dq);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(input logic r, input logic c, input logic w);
    ras_n = r; cas_n = c; we_n = w;
  endtask

  task automatic access(input int col, input bit wr, input int data);
    strobes(0, 1, 1); addr = 10'h2A5; tick();
    addr = 10'(col); dq_in = 4'(data); we_n = !wr; cas_n = 0; tick();
    cas_n = 1; we_n = 1; tick();
    ras_n = 1; tick();
  endtask

  task automatic cbr(input bit wlow);
    strobes(1, 0, !wlow); tick();
    ras_n = 0; addr = 10'h3FF; tick(2);
    strobes(1, 1, 1); tick();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int prev;
    tick(3);
    // R1 reset state
    chk(rf_valid == 0 && cyc_kind == 0 && test_mode == 0 && self_ref == 0 && dq_oe == 0 && dq_out == 0,
        "R1", {rf_valid, cyc_kind, test_mode, self_ref, dq_oe}, 0);
    rst_n = 1; tick(2);
    // R7 writes then reads, EDO page
    access(3, 1, 'hA);
    access(2, 1, 'h5);
    access(3, 0, 0);
    strobes(0, 1, 1); tick();
    addr = 3; cas_n = 0; tick(); cas_n = 1; tick();
    chk(dq_oe == 1 && dq_out == 4'hA, "R7", dq_out, 'hA);
    addr = 2; cas_n = 0; tick(); cas_n = 1; tick();
    ras_n = 1; tick(2);
    // R5 row-address-only refresh
    strobes(0, 1, 1); addr = 10'h1C3; tick(3); ras_n = 1; tick();
    chk(cyc_kind == 3'd2 && dq_oe == 0, "R5", cyc_kind, 2);
    // R3 counter refresh, CAS held low over several row cycles
    strobes(1, 0, 1); tick(); ras_n = 0; tick(); ras_n = 1; tick();
    ras_n = 0; tick(); ras_n = 1; tick(); cas_n = 1; tick();
    // simultaneous fall counts as counter refresh
    strobes(0, 0, 1); tick(); strobes(1, 1, 1); tick();
    // R6 hidden refresh after a read
    strobes(0, 1, 1); tick(); addr = 3; cas_n = 0; tick();
    ras_n = 1; tick(); ras_n = 0; tick();
    chk(cyc_kind == 3'd4 && dq_oe == 1 && dq_out == 4'hA, "R6", dq_out, 'hA);
    strobes(1, 1, 1); tick();
    // R11 / R12 test mode
    cbr(1);
    chk(test_mode == 1, "R11", test_mode, 1);
    access(4, 1, 'h1);
    access(5, 0, 0);
    chk(dq_out == 4'hF, "R12", dq_out, 'hF);
    cbr(0);
    access(4, 1, 'hE);
    cbr(1);
    access(4, 0, 0);
    chk(dq_out == 4'h0, "R12", dq_out, 0);
    strobes(0, 1, 1); tick(2); ras_n = 1; tick();
    chk(test_mode == 0, "R11", test_mode, 0);
    // R8 / R9 / R10 self-refresh
    strobes(1, 0, 1); tick(); ras_n = 0; tick(SRE + 3 * SRI + 5);
    chk(self_ref == 1, "R8", self_ref, 1);
    strobes(1, 1, 1); tick();
    chk(self_ref == 0, "R10", self_ref, 0);
    tick(2);
    // R4 wrap over many counter refreshes
    prev = -1;
    cas_n = 0; tick();
    for (int k = 0; k < 1030; k++) begin
      ras_n = 0; tick();
      if (prev == 1023) chk(rf_row == 0, "R4", rf_row, 0);
      prev = rf_row;
      ras_n = 1; tick();
    end
    strobes(1, 1, 1); tick(3);
    finish_run();
  end
endmodule